// File: doc/BRIEF.md
# Configurable Port Input Capture Bank

This block holds one input cell for every pin of three 8-bit ports, 24 cells in all. Each cell hands its pin onto the logic input bus in one of three ways: straight through, through a transparent latch, or through an edge-triggered register. The pins are grouped in fours: bits 3..0 of a port form one group and bits 7..4 another. Each group has its own enable source. A per-group select bit picks that group's control term or the shared processor address strobe. With the strobe selected, a group can hold high address bits, above bit 15, for the logic to decode during the rest of the bus cycle.

All cells share one system clock. The register mode acts on a rising edge of the selected source, found by comparing it with its value at the previous clock edge. The latch mode follows the pin while the selected source is high and keeps its last value while the source is low. Cell modes and group selects are static configuration inputs.

The captured values feed the logic input bus. A processor read port returns any port's eight bits, registered, one cycle after the read strobe. The read port has no back-pressure. A request is accepted on every clock where `rd_req_i` is high, and the response cannot be stalled, so there is no ready signal.

Top module: `port_capture_bank`

## Requirements
- R1: While `rst_n` is low, every cell's capture state and the read response are 0, so `pld_bus_o` is 0 for latch-mode cells whose enable is low and for all register-mode cells, and `rd_valid_o` and `rd_data_o` are 0.
- R2: A cell with mode code 2'b00 (pass) or 2'b11 (reserved) drives its `pld_bus_o` bit equal to its pin bit in the same cycle.
- R3: A cell with mode code 2'b10 (register) loads its pin at a clock edge where its group's selected enable is high and was low at the previous edge, and holds its value at every other edge, including while the enable stays high.
- R4: A cell with mode code 2'b01 (latch) drives its pin while its group's selected enable is high, and while the enable is low it drives the pin value sampled at the last clock edge where the enable was high.
- R5: Cell c takes its mode from `mode_i[2c+1:2c]` and belongs to group c/4. Group g uses `term_i[g]` as its enable when `src_sel_i[g]` is 0 and `strobe_i` when it is 1. The unselected source has no effect on that group.
- R6: Port p occupies bits 8p+7..8p of `pin_i` and `pld_bus_o`. A read request at a clock edge with `rd_idx_i` = p < 3 gives `rd_valid_o` = 1 and `rd_data_o` equal to `pld_bus_o[8p+7:8p]` as it was at that edge, both in the following cycle.
- R7: A read request with `rd_idx_i` = 3 gives `rd_valid_o` = 1 and `rd_data_o` = 0 in the following cycle. A cycle that follows an edge without a request has `rd_valid_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 24 | Port pins, port p at bits 8p+7..8p |
| term_i | input | 6 | Per-group control terms from the logic array |
| strobe_i | input | 1 | Processor address latch strobe |
| mode_i | input | 48 | Two-bit mode code per cell |
| src_sel_i | input | 6 | Per-group enable source select, 1 = strobe |
| rd_req_i | input | 1 | Processor read strobe |
| rd_idx_i | input | 2 | Port index for the read |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 8 | Registered read data |
| pld_bus_o | output | 24 | Cell outputs to the logic input bus |

## Verification
The assertions assume that every input, the mode and select configuration included, is sampled only at rising clock edges. They take an enable edge to be a change seen between two edges, so an enable pulse narrower than a clock period is treated as absent. The bench changes all inputs on the falling clock edge and holds them for a whole period. It changes the modes and the selects from time to time during random traffic, so a mode switch with data already captured is also exercised. Read requests are random and include the unused index 3.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    CM_PASS  = 2'b00,
    CM_LATCH = 2'b01,
    CM_REG   = 2'b10,
    CM_RSVD  = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/pcb_enable_sel.sv
module pcb_enable_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic term_i,
  input  logic strobe_i,
  input  logic src_sel_i,
  output logic en_o,
  output logic rise_o
);
  logic prev_q;

  assign en_o = src_sel_i ? strobe_i : term_i;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= en_o;
  end

  assign rise_o = en_o & ~prev_q;

  // R3: an edge is reported at most once per high phase
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // R5: an edge is flagged only on the selected source
  p_src_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i && !strobe_i) |-> !rise_o);
endmodule

// File: rtl/pcb_cell.sv
module pcb_cell
  import pcb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       rise_i,
  output logic       out_o
);
  cell_mode_e mode;
  logic       cap_q;

  assign mode = cell_mode_e'(mode_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
    end else begin
      unique case (mode)
        CM_LATCH: if (en_i)   cap_q <= pin_i;
        CM_REG:   if (rise_i) cap_q <= pin_i;
        default:  cap_q <= cap_q;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      CM_LATCH: out_o = en_i ? pin_i : cap_q;
      CM_REG:   out_o = cap_q;
      default:  out_o = pin_i;
    endcase
  end

  // R3: register cell holds when no edge is seen
  p_reg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_REG && !rise_i) |=> $stable(cap_q));

  // R3: register cell loads the pin on an edge
  p_reg_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_REG && rise_i) |=> (cap_q == $past(pin_i)));

  // R4: latch cell holds while enable is low
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_LATCH && !en_i) |=> $stable(cap_q));

  // R4: latch output next cycle with enable low shows last sampled pin
  p_latch_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_LATCH && en_i) |=> (cap_q == $past(pin_i)));
endmodule

// File: rtl/pcb_read_port.sv
module pcb_read_port #(
  parameter int NPORTS = 3,
  parameter int PORT_W = 8,
  parameter int IDX_W  = 2,
  localparam int BUS_W = NPORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              rd_req_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [PORT_W-1:0] rd_data_o
);
  logic [PORT_W-1:0] sel_data;

  always_comb begin
    sel_data = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (rd_idx_i == IDX_W'(p)) sel_data = bus_i[p*PORT_W +: PORT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) rd_data_o <= sel_data;
    end
  end

  // R6: every request gives a response one cycle later
  p_rd_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_valid_o);

  // R7: no request, no response
  p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_valid_o);

  // R7: unused index reads as zero
  p_rd_badidx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && int'(rd_idx_i) >= NPORTS) |=> (rd_data_o == '0));
endmodule

// File: rtl/port_capture_bank.sv
module port_capture_bank #(
  parameter int NPORTS = 3,
  parameter int PORT_W = 8,
  parameter int GRP_W  = 4,
  parameter int IDX_W  = 2,
  localparam int NCELLS = NPORTS * PORT_W,
  localparam int NGRP   = NCELLS / GRP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCELLS-1:0]   pin_i,
  input  logic [NGRP-1:0]     term_i,
  input  logic                strobe_i,
  input  logic [2*NCELLS-1:0] mode_i,
  input  logic [NGRP-1:0]     src_sel_i,
  input  logic                rd_req_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic                rd_valid_o,
  output logic [PORT_W-1:0]   rd_data_o,
  output logic [NCELLS-1:0]   pld_bus_o
);
  logic [NGRP-1:0] grp_en;
  logic [NGRP-1:0] grp_rise;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    pcb_enable_sel u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .term_i    (term_i[g]),
      .strobe_i  (strobe_i),
      .src_sel_i (src_sel_i[g]),
      .en_o      (grp_en[g]),
      .rise_o    (grp_rise[g])
    );
  end

  for (genvar c = 0; c < NCELLS; c++) begin : g_cell
    pcb_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i[c]),
      .mode_i (mode_i[2*c +: 2]),
      .en_i   (grp_en[c/GRP_W]),
      .rise_i (grp_rise[c/GRP_W]),
      .out_o  (pld_bus_o[c])
    );
  end

  pcb_read_port #(
    .NPORTS (NPORTS),
    .PORT_W (PORT_W),
    .IDX_W  (IDX_W)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_i      (pld_bus_o),
    .rd_req_i   (rd_req_i),
    .rd_idx_i   (rd_idx_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  // R6: read data matches the addressed port as it was at the request edge
  p_rd_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && rd_idx_i == '0) |=> (rd_data_o == $past(pld_bus_o[PORT_W-1:0])));
endmodule

// File: tb/port_capture_bank_tb.sv
module port_capture_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] pin;
  logic [5:0]  term;
  logic        strobe;
  logic [47:0] mode;
  logic [5:0]  src;
  logic        rd_req;
  logic [1:0]  rd_idx;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [23:0] bus;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  logic [23:0] m_cap;
  logic [5:0]  m_prev;
  logic        m_rv;
  logic [7:0]  m_rd;
  logic        m_bad;

  always #5 clk = ~clk;

  port_capture_bank u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .term_i(term), .strobe_i(strobe),
    .mode_i(mode), .src_sel_i(src), .rd_req_i(rd_req), .rd_idx_i(rd_idx),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .pld_bus_o(bus)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] en_of();
    logic [5:0] e;
    for (int g = 0; g < 6; g++) e[g] = src[g] ? strobe : term[g];
    return e;
  endfunction

  function automatic logic [23:0] bus_of();
    logic [23:0] b;
    logic [5:0]  e = en_of();
    for (int c = 0; c < 24; c++) begin
      case (mode[2*c +: 2])
        2'b01:   b[c] = e[c/4] ? pin[c] : m_cap[c];
        2'b10:   b[c] = m_cap[c];
        default: b[c] = pin[c];
      endcase
    end
    return b;
  endfunction

  // check outputs for the current inputs, then advance the model one edge
  task automatic cycle();
    logic [23:0] eb;
    logic [5:0]  e;
    #1;
    eb = bus_of();
    e  = en_of();
    for (int c = 0; c < 24; c++) begin
      case (mode[2*c +: 2])
        2'b01:   chk("R4 latch cell", 32'(bus[c]), 32'(eb[c]));
        2'b10:   chk("R3 register cell", 32'(bus[c]), 32'(eb[c]));
        default: chk("R2 pass cell", 32'(bus[c]), 32'(eb[c]));
      endcase
    end
    chk(m_rv ? "R6 rd_valid after request" : "R7 rd_valid idle", 32'(rd_valid), 32'(m_rv));
    if (m_rv) chk(m_bad ? "R7 index 3 data" : "R6 read data", 32'(rd_data), 32'(m_rd));
    for (int c = 0; c < 24; c++) begin
      if (mode[2*c +: 2] == 2'b01 && e[c/4]) m_cap[c] = pin[c];
      if (mode[2*c +: 2] == 2'b10 && e[c/4] && !m_prev[c/4]) m_cap[c] = pin[c];
    end
    m_prev = e;
    m_rv   = rd_req;
    m_bad  = (rd_idx == 2'd3);
    if (rd_req) m_rd = (rd_idx == 2'd3) ? 8'h00 : eb[rd_idx*8 +: 8];
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; pin = '1; term = '1; strobe = 1; mode = {24{2'b10}};
    src = '0; rd_req = 1; rd_idx = 0;
    m_cap = '0; m_prev = '0; m_rv = 0; m_rd = '0; m_bad = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 bus in reset", 32'(bus), 32'h0);
    chk("R1 rd_valid in reset", 32'(rd_valid), 32'h0);
    chk("R1 rd_data in reset", 32'(rd_data), 32'h0);
    @(negedge clk);
    rst_n = 1; term = '0; strobe = 0; rd_req = 0;
    cycle();

    // directed: strobe-selected register groups, strobe held high
    src = '1; pin = 24'hAAAAAA; cycle();
    strobe = 1; pin = 24'h5A5A5A; cycle();
    pin = 24'h123456; cycle();
    strobe = 0; pin = 24'hFFFFFF; cycle();
    #1; chk("R3 single capture while strobe high", 32'(bus), 32'h5A5A5A);
    // directed: group 0 term only, strobe ignored by term-selected groups
    src = 6'b000000; strobe = 1; term = 6'b000001; pin = 24'h0F0F0F; cycle();
    strobe = 0; term = 0; cycle();
    #1; chk("R5 only group 0 captured", 32'(bus), 32'h5A5A5F);
    // directed: latch follow then hold
    mode = {24{2'b01}}; src = 6'b111111; strobe = 1; pin = 24'hC3C3C3; cycle();
    strobe = 0; pin = 24'h000000; cycle();
    #1; chk("R4 latch holds", 32'(bus), 32'hC3C3C3);
    // directed: reads of every index
    for (int i = 0; i < 4; i++) begin
      rd_req = 1; rd_idx = 2'(i); cycle();
    end
    rd_req = 0; cycle();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      pin    = 24'($urandom);
      term   = 6'($urandom);
      strobe = 1'($urandom);
      rd_req = 1'($urandom);
      rd_idx = 2'($urandom);
      if ($urandom_range(0, 49) == 0) begin
        mode = {16'($urandom), 32'($urandom)};
        src  = 6'($urandom);
      end
      cycle();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule